// File: doc/BRIEF.md
# FPU Register-Mode Trap Controller

This block sits inside a floating-point coprocessor and controls a compatibility mode in which every 32-bit access to the FP register file is trapped. The trapped accesses are single-precision arithmetic, word loads and stores to FP registers, and moves between general and FP registers. A read-only feature flag in the FPU implementation word says whether the mode exists at all. Two bits in a processor configuration word hold the mode itself and a switch that lets unprivileged code change the mode.

Unprivileged code reaches the mode through the FP control-register access path. One control index reads the mode and also acts as a clear strobe when written. A second control index acts as a set strobe. A privileged write port loads both configuration bits directly.

For each decoded FP instruction class the block raises a reserved-instruction exception request in the same cycle as the instruction strobe. Control accesses that are not permitted raise the same request. The FP datapath, the pipeline and the vectoring of the exception belong to the surrounding core.

Top module: `fpr_mode_trap_ctl`

## Requirements
- R1: After reset the following values hold. The configuration word is zero. `mode_active` and `exc_ri` are low. `fir_out` bit 29 equals the FEAT_RESET parameter and every other bit of `fir_out` is zero.
- R2: A cycle with `cfg_we` high loads `cfg_mode_wr` into `cfg_out` bit 8 and `cfg_uacc_wr` into `cfg_out` bit 9. The new values are visible after the next rising edge. All other bits of `cfg_out` stay zero.
- R3: A control read (`cr_valid`=1, `cr_write`=0) of index 5 returns the mode bit in `cr_rdata` bit 0, with every other bit zero, when the feature flag is 1 and the user-access bit is 1. It raises no exception.
- R4: A control read of index 5 with the feature flag at 1 and the user-access bit at 0 raises `exc_ri` in that cycle and returns zero.
- R5: A qualifying control write sets the mode bit when it targets index 6 and clears it when it targets index 5. A write qualifies when the feature flag is 1 and `cr_rt` is 0. The write must also have the user-access bit at 1. It raises no exception, and the write carries no data operand.
- R6: A control write to index 5 or 6 with `cr_rt` nonzero, or with the feature flag at 0, changes no state and raises no exception.
- R7: A qualifying control write to index 5 or 6 with the user-access bit at 0 raises `exc_ri` in that cycle and leaves the mode bit unchanged.
- R8: `mode_active` equals the feature flag AND the stored mode bit. It reflects a change one cycle after the edge that stores it.
- R9: While `mode_active` is 1, a cycle with `in_valid` high raises `exc_ri` in that same cycle for these `in_class` codes: 1 single-precision arithmetic, 2 base-form word load, 3 indexed word load, 4 GPR-to-FP move, 5 base-form word store, 6 indexed word store, 7 FP-to-GPR move. Code 0 (any other FP instruction) is never trapped, and nothing is trapped while `in_valid` is low.
- R10: With the feature flag at 0, a read of index 5 returns zero. In that configuration `exc_ri` never rises.
- R11: When `cfg_we` and a qualifying control write occur in the same cycle, the privileged write decides the stored configuration bits.
- R12: Control accesses to indices other than 5 and 6, and reads of index 6, return zero, raise no exception and change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Privileged configuration write strobe |
| cfg_mode_wr | input | 1 | Mode bit value for a privileged write |
| cfg_uacc_wr | input | 1 | User-access bit value for a privileged write |
| cr_valid | input | 1 | Control-register access strobe |
| cr_write | input | 1 | 1 = control write, 0 = control read |
| cr_idx | input | 5 | Control-register index |
| cr_rt | input | 5 | Source register field of the control write |
| cr_rdata | output | 32 | Control read data |
| in_valid | input | 1 | Decoded FP instruction strobe |
| in_class | input | 3 | FP instruction class code (see R9) |
| exc_ri | output | 1 | Reserved-instruction exception request |
| mode_active | output | 1 | Effective trap mode |
| fir_out | output | 32 | FPU implementation word carrying the feature flag |
| cfg_out | output | 32 | Configuration word: mode bit 8, user-access bit 9 |

## Verification
Two conditions are the hardest to reach from the ports.

The first is a control write that qualifies but is refused. It needs the feature flag set, `cr_rt` at zero and user access off, all at once. The bench therefore sets each of the four combinations of mode and user-access bits through the privileged port. Before every control access it restores that state, then sweeps index, direction and `cr_rt`.

The second is a collision between the privileged port and a user set or clear in the same cycle. The bench drives this case directly.

A second instance with the feature flag absent receives identical stimulus, so the bench can confirm that the flag gates everything.

// File: rtl/fmt_pkg.sv
// Package: shared constants and the FP instruction class encoding used by
// the register-mode trap controller. Assumes a 3-bit class code from decode.
package fmt_pkg;

    localparam int CLASS_W     = 3;
    localparam int NUM_CLASSES = 1 << CLASS_W;

    // Decoded FP instruction classes seen by the trap guard.
    typedef enum logic [CLASS_W-1:0] {
        IC_OTHER    = 3'd0,
        IC_SP_ARITH = 3'd1,
        IC_LW_BASE  = 3'd2,
        IC_LW_INDEX = 3'd3,
        IC_MOV_TO   = 3'd4,
        IC_SW_BASE  = 3'd5,
        IC_SW_INDEX = 3'd6,
        IC_MOV_FROM = 3'd7
    } insn_class_e;

    // Classes trapped while the mode is active: everything but IC_OTHER.
    localparam logic [NUM_CLASSES-1:0] TRAP_MASK_DEFAULT = 8'b1111_1110;

endpackage

// File: rtl/fmt_cfg_regs.sv
// Module: holds the mode bit and the user-access bit of the configuration
// word. A privileged load has priority over the user set/clear strobes.
// Assumes set_req and clr_req are never both high (they come from distinct
// control indices).
module fmt_cfg_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_mode_wr,
    input  logic cfg_uacc_wr,
    input  logic set_req,
    input  logic clr_req,
    output logic mode_q,
    output logic uacc_q
);

    // Mode bit: privileged load first, then user set, then user clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (cfg_we) begin
            mode_q <= cfg_mode_wr;
        end else if (set_req) begin
            mode_q <= 1'b1;
        end else if (clr_req) begin
            mode_q <= 1'b0;
        end
    end

    // User-access bit: written only through the privileged port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uacc_q <= 1'b0;
        end else if (cfg_we) begin
            uacc_q <= cfg_uacc_wr;
        end
    end

    // R2 / R11: a privileged write is what gets stored, even against a strobe.
    a_r2_priv_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (mode_q == $past(cfg_mode_wr)) && (uacc_q == $past(cfg_uacc_wr)));

    // R5: a user strobe never touches the user-access bit.
    a_r5_uacc_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && (set_req || clr_req)) |=> $stable(uacc_q));

endmodule

// File: rtl/fmt_ctl_access.sv
// Module: decodes user control-register accesses to the clear/read index and
// the set index. Produces set/clear strobes, read data and the exception for
// refused accesses. Purely combinational; assumes one access per strobe.
module fmt_ctl_access #(
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 5,
    parameter int CLR_IDX = 5,
    parameter int SET_IDX = 6
) (
    input  logic              feat,
    input  logic              mode_q,
    input  logic              uacc_q,
    input  logic              cr_valid,
    input  logic              cr_write,
    input  logic [IDX_W-1:0]  cr_idx,
    input  logic [IDX_W-1:0]  cr_rt,
    output logic              set_req,
    output logic              clr_req,
    output logic              cr_exc,
    output logic [DATA_W-1:0] cr_rdata
);

    logic hit_rd;
    logic hit_clr;
    logic hit_set;
    logic wr_qual;
    logic rd_ok;

    // Index decode of the access.
    always_comb begin
        hit_rd  = cr_valid && !cr_write && (cr_idx == IDX_W'(CLR_IDX));
        hit_clr = cr_valid &&  cr_write && (cr_idx == IDX_W'(CLR_IDX));
        hit_set = cr_valid &&  cr_write && (cr_idx == IDX_W'(SET_IDX));
    end

    // Qualification: feature present and source field zero for writes.
    always_comb begin
        wr_qual = (hit_clr || hit_set) && feat && (cr_rt == '0);
        rd_ok   = hit_rd && feat && uacc_q;
    end

    // Strobes to the configuration registers, only when user access is on.
    always_comb begin
        set_req = wr_qual && uacc_q && hit_set;
        clr_req = wr_qual && uacc_q && hit_clr;
    end

    // Refused accesses: read or qualifying write with user access off.
    always_comb begin
        cr_exc = (hit_rd && feat && !uacc_q) || (wr_qual && !uacc_q);
    end

    // Read data: mode bit in bit 0 when the read is permitted.
    always_comb begin
        cr_rdata = '0;
        if (rd_ok) begin
            cr_rdata[0] = mode_q;
        end
    end

    // R7: a refused access never produces a strobe.
    a_r7_refused_no_strobe: assert final (!(cr_exc && (set_req || clr_req)));

    // R5: set and clear never fire together.
    a_r5_strobe_exclusive: assert final (!(set_req && clr_req));

endmodule

// File: rtl/fmt_insn_guard.sv
// Module: flags decoded FP instructions that must trap while the mode is
// active. The set of trapped classes is a parameter mask; the decoder is
// built by generate, one term per class.
module fmt_insn_guard
    import fmt_pkg::*;
#(
    parameter int                      N_CLS     = NUM_CLASSES,
    parameter logic [N_CLS-1:0]        TRAP_MASK = TRAP_MASK_DEFAULT
) (
    input  logic                       in_valid,
    input  logic [$clog2(N_CLS)-1:0]   in_class,
    input  logic                       mode_active,
    output logic                       insn_exc
);

    localparam int CW = $clog2(N_CLS);

    logic [N_CLS-1:0] cls_hit;

    // One decode term per class, masked by the trap set.
    for (genvar gi = 0; gi < N_CLS; gi++) begin : g_cls
        assign cls_hit[gi] = (in_class == CW'(gi)) && TRAP_MASK[gi];
    end

    // Exception when a trapped class is strobed while the mode is active.
    always_comb begin
        insn_exc = in_valid && mode_active && (|cls_hit);
    end

    // R9: the decoder hits at most one class.
    a_r9_onehot_decode: assert final ($onehot0(cls_hit));

endmodule

// File: rtl/fpr_mode_trap_ctl.sv
// Module (top): register-mode trap controller of an FP coprocessor. Holds the
// read-only feature flag, the mode and user-access configuration bits, serves
// user control-register accesses and raises a reserved-instruction request
// for trapped 32-bit FP accesses. Assumes at most one control access and one
// instruction strobe per cycle; exception vectoring is done outside.
module fpr_mode_trap_ctl
    import fmt_pkg::*;
#(
    parameter int   DATA_W     = 32,
    parameter int   IDX_W      = 5,
    parameter int   FEAT_POS   = 29,
    parameter int   MODE_POS   = 8,
    parameter int   UACC_POS   = 9,
    parameter int   CLR_IDX    = 5,
    parameter int   SET_IDX    = 6,
    parameter logic FEAT_RESET = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_mode_wr,
    input  logic                cfg_uacc_wr,
    input  logic                cr_valid,
    input  logic                cr_write,
    input  logic [IDX_W-1:0]    cr_idx,
    input  logic [IDX_W-1:0]    cr_rt,
    output logic [DATA_W-1:0]   cr_rdata,
    input  logic                in_valid,
    input  logic [CLASS_W-1:0]  in_class,
    output logic                exc_ri,
    output logic                mode_active,
    output logic [DATA_W-1:0]   fir_out,
    output logic [DATA_W-1:0]   cfg_out
);

    logic feat_q;
    logic mode_q;
    logic uacc_q;
    logic set_req;
    logic clr_req;
    logic cr_exc;
    logic insn_exc;

    // Feature flag: read-only, loaded from the parameter at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            feat_q <= FEAT_RESET;
        end
    end

    fmt_cfg_regs u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_mode_wr (cfg_mode_wr),
        .cfg_uacc_wr (cfg_uacc_wr),
        .set_req     (set_req),
        .clr_req     (clr_req),
        .mode_q      (mode_q),
        .uacc_q      (uacc_q)
    );

    fmt_ctl_access #(
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W),
        .CLR_IDX (CLR_IDX),
        .SET_IDX (SET_IDX)
    ) u_ctl (
        .feat     (feat_q),
        .mode_q   (mode_q),
        .uacc_q   (uacc_q),
        .cr_valid (cr_valid),
        .cr_write (cr_write),
        .cr_idx   (cr_idx),
        .cr_rt    (cr_rt),
        .set_req  (set_req),
        .clr_req  (clr_req),
        .cr_exc   (cr_exc),
        .cr_rdata (cr_rdata)
    );

    // Effective mode: feature flag gates the stored mode bit.
    always_comb begin
        mode_active = feat_q && mode_q;
    end

    fmt_insn_guard #(
        .N_CLS     (NUM_CLASSES),
        .TRAP_MASK (TRAP_MASK_DEFAULT)
    ) u_guard (
        .in_valid    (in_valid),
        .in_class    (in_class),
        .mode_active (mode_active),
        .insn_exc    (insn_exc)
    );

    // Single exception request from either source.
    always_comb begin
        exc_ri = cr_exc || insn_exc;
    end

    // Visible words: feature flag and configuration bits at their positions.
    always_comb begin
        fir_out           = '0;
        fir_out[FEAT_POS] = feat_q;
        cfg_out           = '0;
        cfg_out[MODE_POS] = mode_q;
        cfg_out[UACC_POS] = uacc_q;
    end

    // R3: nonzero read data only for a permitted read of the clear index.
    a_r3_rdata_source: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_rdata != '0) |-> (cr_valid && !cr_write && cr_idx == IDX_W'(CLR_IDX) && uacc_q));

    // R6: a write with a nonzero source field leaves the configuration alone.
    a_r6_rt_nonzero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_valid && cr_write && cr_rt != '0 && !cfg_we) |=> $stable(cfg_out));

    // R8: the mode only turns on after a privileged load or a user set.
    a_r8_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_active) |-> $past(cfg_we || set_req));

    // R10: without the feature flag no exception is ever requested.
    a_r10_no_feat_no_exc: assert property (@(posedge clk) disable iff (!rst_n)
        !feat_q |-> !exc_ri);

endmodule

// File: tb/sim_fpr_mode_trap_ctl.sv
// Bench: two instances (feature present / absent) share all stimulus. A
// bench model computes expected outputs from the requirements.
`timescale 1ns/1ps
module sim_fpr_mode_trap_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_mode_wr = 1'b0, cfg_uacc_wr = 1'b0;
    logic        cr_valid = 1'b0, cr_write = 1'b0;
    logic [4:0]  cr_idx = '0, cr_rt = '0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_class = '0;
    logic [31:0] rd0, rd1, fir0, fir1, cfg0, cfg1;
    logic        exc0, exc1, ma0, ma1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state per instance
    logic m_mode [2];
    logic m_uacc [2];
    localparam logic FEAT [2] = '{1'b1, 1'b0};

    always #2.5 clk = ~clk;

    fpr_mode_trap_ctl #(.FEAT_RESET(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode_wr(cfg_mode_wr),
        .cfg_uacc_wr(cfg_uacc_wr), .cr_valid(cr_valid), .cr_write(cr_write),
        .cr_idx(cr_idx), .cr_rt(cr_rt), .cr_rdata(rd0), .in_valid(in_valid),
        .in_class(in_class), .exc_ri(exc0), .mode_active(ma0),
        .fir_out(fir0), .cfg_out(cfg0));

    fpr_mode_trap_ctl #(.FEAT_RESET(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode_wr(cfg_mode_wr),
        .cfg_uacc_wr(cfg_uacc_wr), .cr_valid(cr_valid), .cr_write(cr_write),
        .cr_idx(cr_idx), .cr_rt(cr_rt), .cr_rdata(rd1), .in_valid(in_valid),
        .in_class(in_class), .exc_ri(exc1), .mode_active(ma1),
        .fir_out(fir1), .cfg_out(cfg1));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare all outputs of both instances against the model (outputs settled).
    task automatic check_all(input string tag);
        for (int k = 0; k < 2; k++) begin
            logic rd, wq, e;
            logic [31:0] rdat;
            string t;
            t = (k == 0) ? {tag, " feat=1"} : {tag, " feat=0 R10"};
            rd = cr_valid && !cr_write && cr_idx == 5;
            wq = cr_valid && cr_write && (cr_idx == 5 || cr_idx == 6) && FEAT[k] && cr_rt == 0;
            e  = (rd && FEAT[k] && !m_uacc[k]) || (wq && !m_uacc[k]) ||
                 (in_valid && FEAT[k] && m_mode[k] && in_class != 0);
            rdat = (rd && FEAT[k] && m_uacc[k]) ? {31'b0, m_mode[k]} : 32'b0;
            chk({t, " exc"}, (k == 0) ? {31'b0, exc0} : {31'b0, exc1}, {31'b0, e});
            chk({t, " rdata"}, (k == 0) ? rd0 : rd1, rdat);
            chk({t, " cfg_out R2"}, (k == 0) ? cfg0 : cfg1,
                (32'(m_mode[k]) << 8) | (32'(m_uacc[k]) << 9));
            chk({t, " mode_active R8"}, (k == 0) ? {31'b0, ma0} : {31'b0, ma1},
                {31'b0, FEAT[k] && m_mode[k]});
        end
    endtask

    // Advance the model by one edge with the inputs currently driven.
    task automatic model_step();
        for (int k = 0; k < 2; k++) begin
            logic wq;
            wq = cr_valid && cr_write && (cr_idx == 5 || cr_idx == 6) && FEAT[k] && cr_rt == 0;
            if (cfg_we) begin
                m_mode[k] = cfg_mode_wr;
                m_uacc[k] = cfg_uacc_wr;
            end else if (wq && m_uacc[k]) begin
                m_mode[k] = (cr_idx == 6);
            end
        end
    endtask

    // Drive one cycle of stimulus, check outputs, then step across the edge.
    task automatic apply(input string tag, input logic we, input logic mw, input logic uw,
                         input logic cv, input logic cw, input logic [4:0] idx,
                         input logic [4:0] rt, input logic iv, input logic [2:0] cls);
        @(negedge clk);
        cfg_we = we; cfg_mode_wr = mw; cfg_uacc_wr = uw;
        cr_valid = cv; cr_write = cw; cr_idx = idx; cr_rt = rt;
        in_valid = iv; in_class = cls;
        #1;
        check_all(tag);
        @(posedge clk);
        model_step();
    endtask

    task automatic set_state(input logic mw, input logic uw);
        apply("R2 privileged load", 1'b1, mw, uw, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, 3'd0);
    endtask

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 2; k++) begin m_mode[k] = 1'b0; m_uacc[k] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 fir_out feat=1", fir0, 32'h2000_0000);
        chk("R1 fir_out feat=0", fir1, 32'h0);
        check_all("R1 reset");

        // Control-register sweep over all configuration states (R3..R7, R12).
        for (int st = 0; st < 4; st++) begin
            for (int idx = 0; idx < 8; idx++) begin
                for (int cw = 0; cw < 2; cw++) begin
                    for (int r = 0; r < 2; r++) begin
                        set_state(st[0], st[1]);
                        apply("R3 R4 R5 R6 R7 R12 ctl access", 1'b0, 1'b0, 1'b0, 1'b1,
                              cw[0], 5'(idx), (r == 0) ? 5'd0 : 5'd17, 1'b0, 3'd0);
                        // outputs after the edge show stored state
                        apply("R5 R6 R7 R12 after access", 1'b0, 1'b0, 1'b0, 1'b0,
                              1'b0, 5'd0, 5'd0, 1'b0, 3'd0);
                    end
                end
            end
            // Instruction class sweep (R9), with and without strobe.
            set_state(st[0], st[1]);
            for (int c = 0; c < 8; c++) begin
                for (int v = 0; v < 2; v++) begin
                    apply("R9 class trap", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0,
                          v[0], 3'(c));
                end
            end
        end

        // R5: set then read back, clear then read back, through user access.
        set_state(1'b0, 1'b1);
        apply("R5 user set", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd6, 5'd0, 1'b0, 3'd0);
        apply("R3 readback set", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd5, 5'd0, 1'b0, 3'd0);
        apply("R5 user clear", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd5, 5'd0, 1'b0, 3'd0);
        apply("R3 readback clear", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd5, 5'd0, 1'b0, 3'd0);

        // R11: privileged write collides with user set / clear.
        apply("R11 priv clear vs user set", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 5'd6, 5'd0, 1'b0, 3'd0);
        apply("R11 result", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, 3'd0);
        set_state(1'b0, 1'b1);
        apply("R11 priv set vs user clear", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 5'd5, 5'd0, 1'b0, 3'd0);
        apply("R11 result", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, 3'd0);

        // R8/R9: trap together with an instruction right after a user set.
        set_state(1'b0, 1'b1);
        apply("R8 set", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd6, 5'd0, 1'b1, 3'd1);
        apply("R8 R9 trap next cycle", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 1'b1, 3'd1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule